// File: doc/BRIEF.md
# Subcode frame sync regenerator

This block watches the serial correction-flag line coming from a disc decoder and pulls two facts out of it: the subcode sync flag (F1) and the hold flag (F6). It turns the F1 flags into a regenerated frame sync pulse. A flywheel counter keeps the regenerated pulse running when real syncs go missing, for example while the pickup jumps. It raises a framing error when the real and regenerated syncs disagree or when the host falls a frame behind.

The flag line carries groups made of a one-slot start mark and seven flag slots. The groups are separated by idle gaps. A slot timer re-arms only after the line has been low for a while. It samples each slot in its middle. Slot length, idle gap, frame period, coincidence window and pulse width are all parameters counted in system clock cycles. A host polls the two sticky flags through a one-cycle status-read strobe.

The slot receiver has three states: `RX_QUIET` counts low cycles and moves to `RX_ARMED` once `IDLE_CYC` of them have been seen. Any high cycle restarts that count. `RX_ARMED` moves to `RX_SLOTS` on the first high cycle. `RX_SLOTS` returns to `RX_QUIET` at the end of the eighth slot. The flywheel also has three states. `FW_HUNT` waits for the first F1 and then goes to `FW_TRACK`. `FW_TRACK` fires a synthetic pulse at the predicted time and moves to `FW_LATE`. `FW_LATE` goes back to `FW_TRACK` on a late F1, which realigns the counter. It also goes back when the late window expires, which raises the error.

Top module: `subsync_regen`

## Requirements
- R1: After reset all outputs are 0, and no sync pulse appears for as long as no F1 flag has been decoded.
- R2: A group starts with a start-mark slot at level 1. Slot 1 holds F1 and slot 6 holds F6, with the start mark counted as slot 0. Each slot lasts `SLOT_CYC` cycles and is sampled `SLOT_CYC/2` edges into the slot. An F1 of 1 makes `f1_seen` high for exactly one cycle. That cycle follows the edge lying `SLOT_CYC + SLOT_CYC/2` edges after the edge that first samples the start mark.
- R3: A start mark is recognised only if the line has been low for at least `IDLE_CYC` consecutive cycles before it. Otherwise the whole group is ignored.
- R4: `hold_seen` takes the F6 value of each decoded group and keeps it until the next decoded group.
- R5: The first decoded F1 starts a sync pulse in the cycle after `f1_seen`. Every sync pulse is `PULSE_CYC` cycles wide.
- R6: Once locked, a synthetic pulse starts exactly `FRAME_CYC` cycles after the last sync reference whenever no F1 arrives earlier.
- R7: An F1 up to `WIN_CYC` cycles before the predicted time, or exactly on it, fires the pulse from the F1 itself. This makes the F1 the new reference and raises no error.
- R8: An F1 up to `WIN_CYC` cycles after a synthetic pulse adds no pulse and raises no error. It moves the reference to the F1.
- R9: A synthetic pulse with no F1 within the following `WIN_CYC` cycles sets `frame_err`.
- R10: An F1 outside the window sets `frame_err`, fires a pulse and becomes the new reference.
- R11: `new_frame` is set at the start of each sync pulse and cleared by `stat_rd`. A pulse start in the same cycle as `stat_rd` leaves it set.
- R12: A pulse start while `new_frame` is still set and not being read sets `frame_err`, and `new_frame` stays set.
- R13: `stat_rd` clears `frame_err` unless a new error event occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_line | input | 1 | Serial correction-flag line |
| stat_rd | input | 1 | One-cycle status read strobe from the host |
| f1_seen | output | 1 | One-cycle strobe for a decoded F1 flag |
| hold_seen | output | 1 | F6 hold flag of the latest decoded group |
| sync_pulse | output | 1 | Regenerated frame sync pulse |
| new_frame | output | 1 | Sticky new-frame flag |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The slot receiver is driven with all four F1/F6 combinations. These show that the two flag slots are decoded independently and with the right latency. A group that follows too short a gap checks that arming depends on the idle count. The flywheel is swept with a second F1 at every offset from two cycles beyond the early edge of the window to two beyond its late edge. Each offset is checked for error, pulse count, pulse position and the position of the next synthetic pulse. This separates early acceptance, late realignment and the out-of-window resync. Directed runs of unread frames and of reads that collide with a pulse separate the host overrun from the window error.

// File: rtl/sfs_pkg.sv
`timescale 1ns/1ps
package sfs_pkg;
    // one start-mark slot followed by seven flag slots
    localparam int unsigned SLOTS_PER_GROUP = 8;
    localparam int unsigned F1_SLOT         = 1;
    localparam int unsigned F6_SLOT         = 6;

    typedef enum logic [1:0] {
        RX_QUIET = 2'd0,
        RX_ARMED = 2'd1,
        RX_SLOTS = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        FW_HUNT  = 2'd0,
        FW_TRACK = 2'd1,
        FW_LATE  = 2'd2
    } fw_state_e;
endpackage

// File: rtl/sfs_slot_rx.sv
`timescale 1ns/1ps
module sfs_slot_rx
    import sfs_pkg::*;
#(
    parameter int unsigned SLOT_CYC = 16,
    parameter int unsigned IDLE_CYC = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic f1_stb_o,
    output logic hold_o
);
    localparam int unsigned CW = (SLOT_CYC > 2) ? $clog2(SLOT_CYC) : 1;
    localparam int unsigned IW = $clog2(IDLE_CYC + 1);
    localparam int unsigned SW = $clog2(SLOTS_PER_GROUP);
    localparam logic [CW-1:0] MID_CYC   = CW'(SLOT_CYC / 2);
    localparam logic [CW-1:0] LAST_CYC  = CW'(SLOT_CYC - 1);
    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS_PER_GROUP - 1);
    localparam logic [SW-1:0] SLOT_F1   = SW'(F1_SLOT);
    localparam logic [SW-1:0] SLOT_F6   = SW'(F6_SLOT);
    localparam logic [IW-1:0] QUIET_END = IW'(IDLE_CYC - 1);

    rx_state_e     state_q, state_d;
    logic [CW-1:0] cyc_q;
    logic [SW-1:0] slot_q;
    logic [IW-1:0] quiet_q;
    logic          slot_end, mid_pt;

    assign slot_end = (cyc_q == LAST_CYC);
    assign mid_pt   = (state_q == RX_SLOTS) && (cyc_q == MID_CYC);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_QUIET;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_QUIET: if (!line_i && quiet_q == QUIET_END) state_d = RX_ARMED;
            RX_ARMED: if (line_i) state_d = RX_SLOTS;
            RX_SLOTS: if (slot_end && slot_q == LAST_SLOT) state_d = RX_QUIET;
            default:  state_d = RX_QUIET;
        endcase
    end

    // counters and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q    <= '0;
            slot_q   <= '0;
            quiet_q  <= '0;
            f1_stb_o <= 1'b0;
            hold_o   <= 1'b0;
        end else begin
            f1_stb_o <= mid_pt && (slot_q == SLOT_F1) && line_i;
            if (mid_pt && slot_q == SLOT_F6) hold_o <= line_i;
            unique case (state_q)
                RX_QUIET: begin
                    quiet_q <= line_i ? '0 : quiet_q + IW'(1);
                    cyc_q   <= '0;
                end
                RX_ARMED: begin
                    quiet_q <= '0;
                    if (line_i) begin
                        cyc_q  <= CW'(1);
                        slot_q <= '0;
                    end
                end
                RX_SLOTS: begin
                    quiet_q <= '0;
                    if (slot_end) begin
                        cyc_q  <= '0;
                        slot_q <= slot_q + SW'(1);
                    end else begin
                        cyc_q <= cyc_q + CW'(1);
                    end
                end
                default: begin
                    quiet_q <= '0;
                    cyc_q   <= '0;
                end
            endcase
        end
    end

    AST_F1_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) f1_stb_o |=> !f1_stb_o); // R2
    AST_ARMED_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (state_q == RX_ARMED) |-> $past(!line_i)); // R3
    AST_GROUP_ENDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (state_q == RX_SLOTS && slot_q == LAST_SLOT && slot_end) |=> (state_q == RX_QUIET && quiet_q == '0)); // R3
endmodule

// File: rtl/sfs_flywheel.sv
`timescale 1ns/1ps
module sfs_flywheel
    import sfs_pkg::*;
#(
    parameter int unsigned FRAME_CYC = 1500,
    parameter int unsigned WIN_CYC   = 16,
    parameter int unsigned PULSE_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic f1_i,
    output logic fire_o,
    output logic slip_o,
    output logic sync_o
);
    localparam int unsigned PHW = $clog2(FRAME_CYC);
    localparam int unsigned PCW = $clog2(PULSE_CYC + 1);
    localparam logic [PHW-1:0] PH_LAST  = PHW'(FRAME_CYC - 1);
    localparam logic [PHW-1:0] PH_EARLY = PHW'(FRAME_CYC - 1 - WIN_CYC);
    localparam logic [PHW-1:0] PH_LATE  = PHW'(WIN_CYC - 1);

    fw_state_e      state_q, state_d;
    logic [PHW-1:0] ph_q;
    logic [PCW-1:0] pulse_q;
    logic           reload;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FW_HUNT;
        else        state_q <= state_d;
    end

    // transitions and event outputs
    always_comb begin
        state_d = state_q;
        fire_o  = 1'b0;
        slip_o  = 1'b0;
        reload  = 1'b0;
        unique case (state_q)
            FW_HUNT: begin
                if (f1_i) begin
                    fire_o  = 1'b1;
                    reload  = 1'b1;
                    state_d = FW_TRACK;
                end
            end
            FW_TRACK: begin
                if (f1_i) begin
                    fire_o = 1'b1;
                    reload = 1'b1;
                    slip_o = (ph_q < PH_EARLY);
                end else if (ph_q == PH_LAST) begin
                    fire_o  = 1'b1;
                    reload  = 1'b1;
                    state_d = FW_LATE;
                end
            end
            FW_LATE: begin
                if (f1_i) begin
                    reload  = 1'b1;
                    state_d = FW_TRACK;
                end else if (ph_q == PH_LATE) begin
                    slip_o  = 1'b1;
                    state_d = FW_TRACK;
                end
            end
            default: state_d = FW_HUNT;
        endcase
    end

    // phase counter and pulse stretcher
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= '0;
            pulse_q <= '0;
        end else begin
            if (reload || state_q == FW_HUNT) ph_q <= '0;
            else                              ph_q <= ph_q + PHW'(1);
            if (fire_o)              pulse_q <= PCW'(PULSE_CYC);
            else if (pulse_q != '0)  pulse_q <= pulse_q - PCW'(1);
        end
    end

    assign sync_o = (pulse_q != '0);

    AST_FIRE_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n) fire_o |=> sync_o); // R5
    AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (state_q == FW_HUNT) |-> !sync_o); // R1
    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (state_q != FW_HUNT) |-> (ph_q <= PH_LAST)); // R6
    AST_LATE_AFTER_SYNTH: assert property (@(posedge clk) disable iff (!rst_n) (state_q == FW_LATE && $past(state_q) != FW_LATE) |-> sync_o); // R9
endmodule

// File: rtl/sfs_host_flags.sv
`timescale 1ns/1ps
module sfs_host_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic slip_i,
    input  logic rd_i,
    output logic new_frame_o,
    output logic frame_err_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_frame_o <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            new_frame_o <= (new_frame_o && !rd_i) || fire_i;
            frame_err_o <= (frame_err_o && !rd_i) || slip_i || (fire_i && new_frame_o && !rd_i);
        end
    end

    AST_NEW_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n) fire_i |=> new_frame_o); // R11
    AST_OVERRUN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (fire_i && new_frame_o && !rd_i) |=> (frame_err_o && new_frame_o)); // R12
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_i && !fire_i && !slip_i) |=> (!frame_err_o && !new_frame_o)); // R13
endmodule

// File: rtl/subsync_regen.sv
`timescale 1ns/1ps
module subsync_regen #(
    parameter int unsigned SLOT_CYC  = 16,
    parameter int unsigned IDLE_CYC  = 24,
    parameter int unsigned FRAME_CYC = 1500,
    parameter int unsigned WIN_CYC   = 16,
    parameter int unsigned PULSE_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_line,
    input  logic stat_rd,
    output logic f1_seen,
    output logic hold_seen,
    output logic sync_pulse,
    output logic new_frame,
    output logic frame_err
);
    logic fire, slip;

    sfs_slot_rx #(
        .SLOT_CYC (SLOT_CYC),
        .IDLE_CYC (IDLE_CYC)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (flag_line),
        .f1_stb_o (f1_seen),
        .hold_o   (hold_seen)
    );

    sfs_flywheel #(
        .FRAME_CYC (FRAME_CYC),
        .WIN_CYC   (WIN_CYC),
        .PULSE_CYC (PULSE_CYC)
    ) u_fw (
        .clk    (clk),
        .rst_n  (rst_n),
        .f1_i   (f1_seen),
        .fire_o (fire),
        .slip_o (slip),
        .sync_o (sync_pulse)
    );

    sfs_host_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_i      (fire),
        .slip_i      (slip),
        .rd_i        (stat_rd),
        .new_frame_o (new_frame),
        .frame_err_o (frame_err)
    );

    AST_SYNC_AFTER_F1_IN_HUNT: assert property (@(posedge clk) disable iff (!rst_n) (f1_seen && !sync_pulse && !new_frame && !frame_err) |=> (sync_pulse && new_frame)); // R5
endmodule

// File: tb/subsync_regen_tb.sv
`timescale 1ns/1ps
module subsync_regen_tb;
    localparam int SLOT  = 8;
    localparam int IDLE  = 12;
    localparam int FRAME = 400;
    localparam int WIN   = 8;
    localparam int PULSE = 6;
    localparam int F1_LAT   = SLOT + SLOT / 2 + 1;
    localparam int SYNC_LAT = F1_LAT + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line = 1'b0;
    logic rd = 1'b0;
    logic f1_seen, hold_seen, sync_pulse, new_frame, frame_err;

    int t = 0, checks = 0, fails = 0;
    int rises = 0, last_rise = -1, f1_cnt = 0, last_f1 = -1;
    int run_len = 0, last_width = 0;
    logic sp_prev = 1'b0;

    always #10 clk = ~clk;

    subsync_regen #(
        .SLOT_CYC (SLOT), .IDLE_CYC (IDLE), .FRAME_CYC (FRAME),
        .WIN_CYC (WIN), .PULSE_CYC (PULSE)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .flag_line (line), .stat_rd (rd),
        .f1_seen (f1_seen), .hold_seen (hold_seen), .sync_pulse (sync_pulse),
        .new_frame (new_frame), .frame_err (frame_err)
    );

    task automatic step();
        @(negedge clk);
        t = t + 1;
        if (sync_pulse && !sp_prev) begin rises = rises + 1; last_rise = t; end
        if (!sync_pulse && sp_prev) last_width = run_len;
        run_len = sync_pulse ? run_len + 1 : 0;
        sp_prev = sync_pulse;
        if (f1_seen) begin f1_cnt = f1_cnt + 1; last_f1 = t; end
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s at t=%0d: actual %0d expected %0d", tag, t, act, exp);
        end
    endtask

    task automatic idle_for(input int n);
        line = 1'b0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic idle_until(input int target);
        line = 1'b0;
        while (t < target) step();
    endtask

    task automatic send_group(input logic f1b, input logic f6b);
        for (int s = 0; s < 8; s++) begin
            line = (s == 0) ? 1'b1 : (s == 1) ? f1b : (s == 6) ? f6b : 1'b0;
            for (int c = 0; c < SLOT; c++) step();
        end
        line = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; line = 1'b0; rd = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic read_status();
        rd = 1'b1;
        step();
        rd = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        fails = fails + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n0, n1, s, c0, r0, exp_err, exp_r, exp_last;
        string tag;

        // R1: reset values and silence without F1
        do_reset();
        check("R1 outputs after reset", int'({f1_seen, hold_seen, sync_pulse, new_frame, frame_err}), 0);
        r0 = rises;
        idle_for(2 * FRAME);
        check("R1 no pulse while hunting", rises - r0, 0);

        // R2 R4 R5 R11: all four F1/F6 combinations
        for (int p = 0; p < 4; p++) begin
            do_reset();
            idle_for(IDLE + 4);
            n0 = t; c0 = f1_cnt; r0 = rises;
            send_group(p[0], p[1]);
            check("R2 f1 strobe count", f1_cnt - c0, int'(p[0]));
            if (p[0]) check("R2 f1 strobe timing", last_f1, n0 + F1_LAT);
            check("R4 hold follows F6", int'(hold_seen), int'(p[1]));
            check("R5 pulse count", rises - r0, int'(p[0]));
            if (p[0]) begin
                check("R5 pulse start", last_rise, n0 + SYNC_LAT);
                check("R5 pulse width", last_width, PULSE);
            end
            check("R11 new_frame on pulse", int'(new_frame), int'(p[0]));
        end
        idle_for(IDLE + 4);
        check("R4 hold kept between groups", int'(hold_seen), 1);
        send_group(1'b0, 1'b0);
        check("R4 hold cleared by next group", int'(hold_seen), 0);

        // R3: short gap ignores the group
        do_reset();
        idle_for(IDLE + 4);
        send_group(1'b0, 1'b0);
        c0 = f1_cnt; r0 = rises;
        idle_for(IDLE - 4);
        send_group(1'b1, 1'b0);
        check("R3 short-gap group ignored", f1_cnt - c0, 0);
        check("R3 no pulse from ignored group", rises - r0, 0);
        idle_for(IDLE + 1);
        n0 = t;
        send_group(1'b1, 1'b0);
        check("R3 group after full gap decoded", last_f1, n0 + F1_LAT);

        // R6 R7 R8 R9 R10: window sweep
        for (int d = -(WIN + 2); d <= WIN + 2; d++) begin
            do_reset();
            idle_for(IDLE + 4);
            n0 = t;
            send_group(1'b1, 1'b0);
            read_status();
            n1 = n0 + FRAME + d;
            idle_until(n1);
            r0 = rises;
            send_group(1'b1, 1'b0);
            exp_err  = (d > WIN || d < -WIN) ? 1 : 0;
            exp_r    = (d > WIN) ? 2 : 1;
            exp_last = (d >= 1 && d <= WIN) ? n0 + SYNC_LAT + FRAME : n1 + SYNC_LAT;
            if (d < -WIN || d > WIN) tag = $sformatf("R10 offset %0d", d);
            else if (d <= 0)         tag = $sformatf("R7 offset %0d", d);
            else                     tag = $sformatf("R8 offset %0d", d);
            check(tag, int'(frame_err), exp_err);
            check(tag, rises - r0, exp_r);
            check(tag, last_rise, exp_last);
            read_status();
            s = n1 + SYNC_LAT + FRAME;
            idle_until(s + WIN - 1);
            check($sformatf("R6 next synthetic, offset %0d", d), last_rise, s);
            check($sformatf("R9 no error inside window, offset %0d", d), int'(frame_err), 0);
            step();
            check($sformatf("R9 error after window, offset %0d", d), int'(frame_err), 1);
        end

        // R11: read colliding with a pulse start
        do_reset();
        idle_for(IDLE + 4);
        n0 = t;
        send_group(1'b1, 1'b0);
        s = n0 + SYNC_LAT + FRAME;
        idle_until(s - 1);
        rd = 1'b1;
        step();
        rd = 1'b0;
        check("R11 set wins over read", int'(new_frame), 1);
        check("R11 read suppresses overrun", int'(frame_err), 0);

        // R12 R13: unread frame overrun, then read clears
        do_reset();
        idle_for(IDLE + 4);
        n0 = t;
        send_group(1'b1, 1'b0);
        s = n0 + SYNC_LAT + FRAME;
        idle_until(s - 1);
        check("R12 no error before overrun", int'(frame_err), 0);
        step();
        check("R12 overrun sets error", int'(frame_err), 1);
        check("R12 new_frame stays set", int'(new_frame), 1);
        read_status();
        check("R13 read clears error", int'(frame_err), 0);
        check("R13 read clears new_frame", int'(new_frame), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule